// File: doc/BRIEF.md
# Inverted Page Table Search Engine

This block holds one translation table shared by every process in the system. The table has one slot per physical frame. Each slot records which process owns the frame and which virtual page of that process sits in it, together with a valid flag. Software fills or clears slots through a write port that is addressed by frame number.

A translation request gives a process identifier and a virtual page number. The engine then walks the table one slot per clock, starting at slot zero. It stops at the first valid slot whose owner and page both equal the request. The position of that slot is the physical frame, so the frame number comes out directly with no stored value. If the walk reaches the last slot without a match, the engine raises a fault flag and the caller handles the miss.

While a walk is running, writes are held off. This keeps the table stable under the search. A held write completes once the walk has ended.

Top module: `ipt_search`

## Requirements
- R1: After reset every slot is invalid, `lk_busy`, `lk_done`, `lk_hit` and `lk_fault` are low, `lk_frame` is zero and `wr_ready` is high.
- R2: On a clock edge where `wr_req` and `wr_ready` are both high, slot `wr_frame` takes the valid flag `wr_valid`, owner `wr_pid` and page `wr_vpn`; a later search sees the new contents.
- R3: A request is accepted on an edge where `lk_start` is high and `lk_busy` is low, and `lk_busy` is high from the next cycle on; `lk_start` while `lk_busy` is high is ignored and does not change the running search or its result.
- R4: A slot matches only if its valid flag is 1 and both its stored owner and its stored page equal the request; `lk_frame` on a hit is the index of the matching slot.
- R5: When the first matching slot has index k, `lk_done` is high k+1 cycles after the accepting edge, with `lk_hit`=1 and `lk_fault`=0.
- R6: When several valid slots match, the one with the lowest index is reported.
- R7: When no slot matches, `lk_done` is high NUM_FRAMES cycles after the accepting edge, with `lk_fault`=1, `lk_hit`=0 and `lk_frame`=0.
- R8: `wr_ready` is low exactly while `lk_busy` is high; a write request held during a search takes effect on the first edge after the search ends.
- R9: `lk_done` is a one-cycle pulse and `lk_busy` is low in that cycle; `lk_hit`, `lk_fault` and `lk_frame` change only when `lk_done` rises and hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Slot write request |
| wr_frame | input | FRAME_W | Slot (frame) index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_pid | input | PID_W | Owner process identifier to store |
| wr_vpn | input | VPN_W | Virtual page number to store |
| wr_ready | output | 1 | Write is accepted this cycle |
| lk_start | input | 1 | Start a translation |
| lk_pid | input | PID_W | Requesting process identifier |
| lk_vpn | input | VPN_W | Requested virtual page number |
| lk_busy | output | 1 | Search in progress |
| lk_done | output | 1 | One-cycle completion pulse |
| lk_hit | output | 1 | Last search found a match |
| lk_fault | output | 1 | Last search found no match |
| lk_frame | output | FRAME_W | Frame index of the last hit |

## Verification
On every cycle the checker confirms that writes are blocked while a walk runs and that completion is a single pulse that ends the busy phase. It also counts the busy cycles of each walk and compares that count with the reported frame on a hit, or with the table size on a fault. It confirms that hit and fault are exclusive and that results move only at completion. Whether the correct slot was chosen can only be shown by the bench's scenarios. Those scenarios include owner-only and page-only matches, invalidated slots, duplicate entries, a hit in the last slot, a start ignored mid-walk, a write held across a walk and back-to-back requests, all compared against a behavioural table model.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
   typedef enum logic [0:0] {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_t;
endpackage

// File: rtl/ipt_entry_store.sv
module ipt_entry_store #(
   parameter int NUM_FRAMES = 16,
   parameter int PID_W      = 4,
   parameter int VPN_W      = 8,
   localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [FRAME_W-1:0] w_idx,
   input  logic               w_valid,
   input  logic [PID_W-1:0]   w_pid,
   input  logic [VPN_W-1:0]   w_vpn,
   input  logic [FRAME_W-1:0] r_idx,
   output logic               r_valid,
   output logic [PID_W-1:0]   r_pid,
   output logic [VPN_W-1:0]   r_vpn
);
   logic [NUM_FRAMES-1:0] slot_valid;
   logic [PID_W-1:0]      slot_pid [NUM_FRAMES];
   logic [VPN_W-1:0]      slot_vpn [NUM_FRAMES];

   for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_slot
      logic sel;
      assign sel = we && (w_idx == FRAME_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_valid[g] <= 1'b0;
            slot_pid[g]   <= '0;
            slot_vpn[g]   <= '0;
         end else if (sel) begin
            slot_valid[g] <= w_valid;
            slot_pid[g]   <= w_pid;
            slot_vpn[g]   <= w_vpn;
         end
      end
   end

   always_comb begin
      r_valid = 1'b0;
      r_pid   = '0;
      r_vpn   = '0;
      for (int i = 0; i < NUM_FRAMES; i++) begin
         if (r_idx == FRAME_W'(i)) begin
            r_valid = slot_valid[i];
            r_pid   = slot_pid[i];
            r_vpn   = slot_vpn[i];
         end
      end
   end
endmodule

// File: rtl/ipt_tag_cmp.sv
module ipt_tag_cmp #(
   parameter int PID_W = 4,
   parameter int VPN_W = 8
) (
   input  logic             e_valid,
   input  logic [PID_W-1:0] e_pid,
   input  logic [VPN_W-1:0] e_vpn,
   input  logic [PID_W-1:0] k_pid,
   input  logic [VPN_W-1:0] k_vpn,
   output logic             match
);
   logic pid_eq;
   logic vpn_eq;
   assign pid_eq = (e_pid == k_pid);
   assign vpn_eq = (e_vpn == k_vpn);
   assign match  = e_valid && pid_eq && vpn_eq;
endmodule

// File: rtl/ipt_scan_fsm.sv
module ipt_scan_fsm
   import ipt_pkg::*;
#(
   parameter int NUM_FRAMES = 16,
   parameter int PID_W      = 4,
   parameter int VPN_W      = 8,
   localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
   localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(NUM_FRAMES - 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PID_W-1:0]   req_pid,
   input  logic [VPN_W-1:0]   req_vpn,
   input  logic               slot_match,
   output logic [FRAME_W-1:0] cur_idx,
   output logic [PID_W-1:0]   key_pid,
   output logic [VPN_W-1:0]   key_vpn,
   output logic               busy,
   output logic               done,
   output logic               hit,
   output logic               fault,
   output logic [FRAME_W-1:0] frame
);
   scan_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SCAN_IDLE;
         cur_idx <= '0;
         key_pid <= '0;
         key_vpn <= '0;
         done    <= 1'b0;
         hit     <= 1'b0;
         fault   <= 1'b0;
         frame   <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SCAN_IDLE: begin
               if (start) begin
                  key_pid <= req_pid;
                  key_vpn <= req_vpn;
                  cur_idx <= '0;
                  state   <= SCAN_RUN;
               end
            end
            SCAN_RUN: begin
               if (slot_match) begin
                  done  <= 1'b1;
                  hit   <= 1'b1;
                  fault <= 1'b0;
                  frame <= cur_idx;
                  state <= SCAN_IDLE;
               end else if (cur_idx == LAST_IDX) begin
                  done  <= 1'b1;
                  hit   <= 1'b0;
                  fault <= 1'b1;
                  frame <= '0;
                  state <= SCAN_IDLE;
               end else begin
                  cur_idx <= cur_idx + 1'b1;
               end
            end
            default: state <= SCAN_IDLE;
         endcase
      end
   end

   assign busy = (state == SCAN_RUN);
endmodule

// File: rtl/ipt_search.sv
module ipt_search #(
   parameter int NUM_FRAMES = 16,
   parameter int PID_W      = 4,
   parameter int VPN_W      = 8,
   localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_req,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic               wr_valid,
   input  logic [PID_W-1:0]   wr_pid,
   input  logic [VPN_W-1:0]   wr_vpn,
   output logic               wr_ready,
   input  logic               lk_start,
   input  logic [PID_W-1:0]   lk_pid,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               lk_busy,
   output logic               lk_done,
   output logic               lk_hit,
   output logic               lk_fault,
   output logic [FRAME_W-1:0] lk_frame
);
   if (NUM_FRAMES < 2) begin : g_bad_frames
      $error("ipt_search: NUM_FRAMES must be at least 2");
   end
   if (PID_W < 1 || VPN_W < 1) begin : g_bad_width
      $error("ipt_search: PID_W and VPN_W must be positive");
   end

   logic [FRAME_W-1:0] scan_idx;
   logic [PID_W-1:0]   key_pid;
   logic [VPN_W-1:0]   key_vpn;
   logic               e_valid;
   logic [PID_W-1:0]   e_pid;
   logic [VPN_W-1:0]   e_vpn;
   logic               e_match;
   logic               busy;
   logic               write_en;

   assign wr_ready = !busy;
   assign write_en = wr_req && wr_ready;
   assign lk_busy  = busy;

   ipt_entry_store #(
      .NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(write_en), .w_idx(wr_frame), .w_valid(wr_valid),
      .w_pid(wr_pid), .w_vpn(wr_vpn),
      .r_idx(scan_idx), .r_valid(e_valid), .r_pid(e_pid), .r_vpn(e_vpn)
   );

   ipt_tag_cmp #(.PID_W(PID_W), .VPN_W(VPN_W)) u_cmp (
      .e_valid(e_valid), .e_pid(e_pid), .e_vpn(e_vpn),
      .k_pid(key_pid), .k_vpn(key_vpn), .match(e_match)
   );

   ipt_scan_fsm #(
      .NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start(lk_start), .req_pid(lk_pid), .req_vpn(lk_vpn),
      .slot_match(e_match), .cur_idx(scan_idx),
      .key_pid(key_pid), .key_vpn(key_vpn),
      .busy(busy), .done(lk_done), .hit(lk_hit), .fault(lk_fault),
      .frame(lk_frame)
   );
endmodule

// File: rtl/ipt_search_chk.sv
module ipt_search_chk #(
   parameter int NUM_FRAMES = 16,
   localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
   localparam int CNT_W     = $clog2(NUM_FRAMES + 1) + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_ready,
   input logic               lk_start,
   input logic               lk_busy,
   input logic               lk_done,
   input logic               lk_hit,
   input logic               lk_fault,
   input logic [FRAME_W-1:0] lk_frame
);
   logic [CNT_W-1:0] walk_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     walk_cnt <= '0;
      else if (lk_start && !lk_busy)  walk_cnt <= '0;
      else if (lk_busy)               walk_cnt <= walk_cnt + 1'b1;
   end

   AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready == !lk_busy); // R8
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_start && !lk_busy) |=> lk_busy); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |=> !lk_done); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> !lk_busy); // R9
   AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> (lk_hit != lk_fault)); // R7
   AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_hit) |-> (int'(walk_cnt) == int'(lk_frame) + 1)); // R5
   AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_fault) |-> (int'(walk_cnt) == NUM_FRAMES && lk_frame == '0)); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_done |-> ($stable(lk_hit) && $stable(lk_fault) && $stable(lk_frame))); // R9
endmodule

bind ipt_search ipt_search_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .lk_start(lk_start),
   .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit),
   .lk_fault(lk_fault), .lk_frame(lk_frame)
);

// File: tb/ipt_search_test.sv
`timescale 1ns/1ps
module ipt_search_test;
   localparam int N  = 16;
   localparam int FW = 4;
   localparam int PW = 4;
   localparam int VW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_req = 1'b0, wr_valid = 1'b0;
   logic [FW-1:0] wr_frame = '0;
   logic [PW-1:0] wr_pid = '0, lk_pid = '0;
   logic [VW-1:0] wr_vpn = '0, lk_vpn = '0;
   logic lk_start = 1'b0;
   logic wr_ready, lk_busy, lk_done, lk_hit, lk_fault;
   logic [FW-1:0] lk_frame;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ipt_search #(.NUM_FRAMES(N), .PID_W(PW), .VPN_W(VW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_frame(wr_frame),
      .wr_valid(wr_valid), .wr_pid(wr_pid), .wr_vpn(wr_vpn),
      .wr_ready(wr_ready), .lk_start(lk_start), .lk_pid(lk_pid),
      .lk_vpn(lk_vpn), .lk_busy(lk_busy), .lk_done(lk_done),
      .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_frame(lk_frame)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural model: table arrays, countdown to completion
   int mv[N], mp[N], mvp[N];
   bit m_busy = 0, m_done = 0, m_hit = 0, m_fault = 0;
   int m_frame = 0, m_cnt = 0;
   bit p_hit; int p_frame;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin mv[i] = 0; mp[i] = 0; mvp[i] = 0; end
         m_busy = 0; m_done = 0; m_hit = 0; m_fault = 0; m_frame = 0; m_cnt = 0;
      end else begin
         bit was_busy;
         was_busy = m_busy;
         m_done = 0;
         if (wr_req && !was_busy) begin
            mv[wr_frame] = wr_valid; mp[wr_frame] = wr_pid; mvp[wr_frame] = wr_vpn;
         end
         if (was_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1;
               m_hit = p_hit; m_fault = !p_hit; m_frame = p_hit ? p_frame : 0;
            end
         end else if (lk_start) begin
            p_hit = 0; p_frame = 0;
            for (int i = N - 1; i >= 0; i--)
               if (mv[i] != 0 && mp[i] == lk_pid && mvp[i] == lk_vpn) begin
                  p_hit = 1; p_frame = i;
               end
            m_busy = 1;
            m_cnt = p_hit ? p_frame + 1 : N;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R3", "busy", lk_busy, m_busy);
         chk("R8", "wr_ready", wr_ready, !m_busy);
         chk("R5", "done", lk_done, m_done);
         chk("R9", "hit", lk_hit, m_hit);
         chk("R7", "fault", lk_fault, m_fault);
         chk("R4", "frame", lk_frame, m_frame);
      end
   end

   task automatic do_write(input int f, input bit v, input int p, input int vp);
      bit r;
      wr_req = 1; wr_frame = FW'(f); wr_valid = v; wr_pid = PW'(p); wr_vpn = VW'(vp);
      forever begin
         r = wr_ready;
         @(negedge clk);
         if (r) break;
      end
      wr_req = 0;
   endtask

   task automatic do_lookup(input int p, input int vp);
      lk_start = 1; lk_pid = PW'(p); lk_vpn = VW'(vp);
      @(negedge clk);
      lk_start = 0;
      while (!lk_done) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "busy", lk_busy, 0);
      chk("R1", "done", lk_done, 0);
      chk("R1", "hit", lk_hit, 0);
      chk("R1", "fault", lk_fault, 0);
      chk("R1", "frame", lk_frame, 0);
      chk("R1", "wr_ready", wr_ready, 1);
      rst_n = 1;
      @(negedge clk);
      // R1: empty table faults
      do_lookup(0, 0);
      chk("R1", "empty table fault", lk_fault, 1);
      // R2: fill slots
      do_write(0, 1, 1, 8'h10);
      do_write(5, 1, 2, 8'h20);
      do_write(N - 1, 1, 3, 8'h30);
      do_write(7, 1, 1, 8'h20);
      do_lookup(1, 8'h10);
      chk("R5", "hit slot0", lk_frame, 0);
      do_lookup(2, 8'h20);
      chk("R4", "pid+vpn slot5", lk_frame, 5);
      do_lookup(1, 8'h20);
      chk("R4", "pid+vpn slot7", lk_frame, 7);
      do_lookup(3, 8'h30);
      chk("R5", "last slot hit", lk_frame, N - 1);
      // R4: owner matches but page differs, page matches but owner differs
      do_lookup(1, 8'h30);
      chk("R4", "page mismatch fault", lk_fault, 1);
      do_lookup(4, 8'h10);
      chk("R4", "owner mismatch fault", lk_fault, 1);
      // R6: duplicate entries, lowest wins
      do_write(9, 1, 2, 8'h20);
      do_write(3, 1, 2, 8'h20);
      do_lookup(2, 8'h20);
      chk("R6", "lowest index", lk_frame, 3);
      // R2/R4: invalidate slot 3 -> slot 5 next
      do_write(3, 0, 2, 8'h20);
      do_lookup(2, 8'h20);
      chk("R4", "invalid slot skipped", lk_frame, 5);
      // R3: start while busy is ignored
      lk_start = 1; lk_pid = 4'd9; lk_vpn = 8'h99;
      @(negedge clk);
      lk_pid = 4'd1; lk_vpn = 8'h10;
      @(negedge clk);
      lk_start = 0;
      while (!lk_done) @(negedge clk);
      chk("R3", "second start ignored", lk_fault, 1);
      // R8: write held across a walk
      fork
         do_lookup(5, 8'h55);
         begin
            @(negedge clk);
            do_write(2, 1, 5, 8'h55);
         end
      join
      chk("R8", "held write not seen mid-walk", lk_fault, 1);
      do_lookup(5, 8'h55);
      chk("R8", "held write applied", lk_frame, 2);
      // R9: back-to-back and result hold
      do_lookup(1, 8'h10);
      do_lookup(3, 8'h30);
      repeat (3) @(negedge clk);
      chk("R9", "frame held", lk_frame, N - 1);
      // random mix
      for (int n = 0; n < 300; n++) begin
         if ($urandom_range(0, 1) == 0)
            do_write($urandom_range(0, N - 1), $urandom_range(0, 3) != 0,
                     $urandom_range(0, 3), $urandom_range(0, 3));
         else
            do_lookup($urandom_range(0, 3), $urandom_range(0, 3));
      end
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule